// File: doc/BRIEF.md
# Interprocessor Interrupt Destination Matcher

This block takes an interrupt command issued by one of N local interrupt units and works out which units receive it. A command is a pair of 32-bit words. Writing the low word (with the high word presented at the same time) both stores the command and starts the send. The block then decodes the target set from the shorthand field, or from the 8-bit destination in the high word. For that decode it uses physical ID comparison, flat logical matching or cluster logical matching, checking each unit's ID, logical destination and destination-format registers.

For lowest-priority delivery the matching units form a request bitmap. A rotating pointer picks exactly one of them, so repeated lowest-priority sends spread across the eligible units. The result is a one-cycle pulse carrying a per-unit target mask. The decoded vector, delivery mode, destination mode, level and trigger bits stay on the outputs until the next accepted command. Queueing into each unit is left to the consumer of the mask.

The controller is a four-state machine:
- IDLE: waits for a command write. A write in this state is accepted, taking the transition to EVAL.
- EVAL: evaluates every unit's match. It goes to PICK when the delivery mode is lowest priority, otherwise to EMIT.
- PICK: applies round-robin selection, then goes to EMIT.
- EMIT: presents the target mask for one cycle and returns to IDLE.

Top module: `ipi_dest_match`

## Requirements
- R1: An accepted command stores the low word with bit 12 (delivery status) forced to 0, and the high word with bits 23:0 forced to 0. It decodes vector = low[7:0], delivery mode = low[10:8], destination mode = low[11] (0 physical, 1 logical), level = low[14], trigger = low[15] and shorthand = low[19:18]. The destination is high[31:24].
- R2: A write taken in IDLE raises busy from the next cycle. The target pulse (tgt_valid) lasts exactly one cycle. It comes two cycles after the write edge for non-lowest modes and three cycles after for lowest priority (mode 1), and busy falls with it. Writes while busy are ignored. tgt_mask is zero whenever tgt_valid is low.
- R3: Shorthand 1 targets only the sender unit.
- R4: Shorthand 2 targets every unit. Shorthand 3 targets every unit except the sender.
- R5: With shorthand 0 and physical destination mode, unit i matches when bits 31:24 of its ID register equal the destination.
- R6: With shorthand 0, logical mode and a destination-format register of all ones, unit i matches when (bits 31:24 of its logical destination register) AND destination is nonzero.
- R7: With shorthand 0, logical mode and any other destination-format value, unit i matches when its logical ID low nibble equals the destination low nibble and the high nibbles ANDed are nonzero.
- R8: In lowest-priority mode exactly one matching unit is targeted. It is the first set bit found scanning upward (with wrap) from the round-robin pointer. The pointer then moves to the unit after the chosen one.
- R9: A lowest-priority command with no matching unit targets nothing and leaves the pointer unchanged.
- R10: Delivery mode 3 (reserved) always yields an empty target mask.
- R11: After reset the block is idle, all outputs are zero and the round-robin pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command low-word write; starts a send |
| cmd_lo | input | 32 | Command low word |
| cmd_hi | input | 32 | Command high word (destination in 31:24) |
| sender_idx | input | IDX_W | Index of the issuing unit |
| unit_id | input | N_UNITS*32 | ID registers, unit i at [i*32 +: 32] |
| unit_ldr | input | N_UNITS*32 | Logical destination registers |
| unit_dfr | input | N_UNITS*32 | Destination-format registers |
| busy | output | 1 | Command in progress |
| tgt_valid | output | 1 | One-cycle target pulse |
| tgt_mask | output | N_UNITS | Per-unit target set |
| lo_word | output | 32 | Stored low word |
| hi_word | output | 32 | Stored high word |
| vector | output | 8 | Decoded vector |
| dmode | output | 3 | Decoded delivery mode |
| logical | output | 1 | Decoded destination mode |
| level | output | 1 | Decoded level bit |
| trig | output | 1 | Decoded trigger bit |

## Verification
The hardest case to reach is the round-robin pointer wrapping past the top unit when the match set is sparse. It is equally hard to show that an empty lowest-priority send leaves the pointer untouched, because the pointer never appears at a port. The stimulus walks the pointer with all-unit lowest-priority sends, then narrows the match set with physical and flat logical destinations until the pick must wrap. It then sends an empty set and follows it with an all-unit send, whose chosen unit reveals where the pointer stands.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVAL,
        ST_PICK,
        ST_EMIT
    } ipi_state_t;

    localparam logic [2:0] DM_FIXED  = 3'd0;
    localparam logic [2:0] DM_LOWEST = 3'd1;
    localparam logic [2:0] DM_RSVD   = 3'd3;

    localparam logic [1:0] SH_DEST   = 2'd0;
    localparam logic [1:0] SH_SELF   = 2'd1;
    localparam logic [1:0] SH_ALL    = 2'd2;
    localparam logic [1:0] SH_OTHERS = 2'd3;

    localparam int STATUS_BIT = 12;
    localparam logic [31:0] FLAT_FORMAT = 32'hFFFF_FFFF;
endpackage

// File: rtl/unit_match.sv
module unit_match #(
    parameter int IDX_W    = 3,
    parameter int UNIT_IDX = 0
) (
    input  logic [1:0]       shorthand,
    input  logic             logical,
    input  logic [7:0]       dest,
    input  logic [IDX_W-1:0] sender,
    input  logic [31:0]      id_reg,
    input  logic [31:0]      ldr_reg,
    input  logic [31:0]      dfr_reg,
    output logic             hit
);
    import ipi_pkg::*;

    logic [7:0] phys_id;
    logic [7:0] log_id;
    logic       is_self;
    logic       flat_hit;
    logic       clus_hit;
    logic       unused_low;

    assign phys_id    = id_reg[31:24];
    assign log_id     = ldr_reg[31:24];
    assign is_self    = (sender == IDX_W'(UNIT_IDX));
    assign flat_hit   = |(log_id & dest);
    assign clus_hit   = (log_id[3:0] == dest[3:0]) && (|(log_id[7:4] & dest[7:4]));
    assign unused_low = ^{id_reg[23:0], ldr_reg[23:0]};

    always_comb begin
        hit = 1'b0;
        unique case (shorthand)
            SH_DEST: begin
                if (!logical)
                    hit = (phys_id == dest);
                else if (dfr_reg == FLAT_FORMAT)
                    hit = flat_hit;
                else
                    hit = clus_hit;
            end
            SH_SELF:   hit = is_self;
            SH_ALL:    hit = 1'b1;
            SH_OTHERS: hit = !is_self;
        endcase
    end
endmodule

// File: rtl/rr_picker.sv
module rr_picker #(
    parameter int N_UNITS = 8,
    localparam int IDX_W  = $clog2(N_UNITS)
) (
    input  logic [N_UNITS-1:0] req,
    input  logic [IDX_W-1:0]   ptr,
    output logic [N_UNITS-1:0] grant,
    output logic               any,
    output logic [IDX_W-1:0]   next_ptr
);
    always_comb begin
        grant    = '0;
        any      = 1'b0;
        next_ptr = ptr;
        for (int k = 0; k < N_UNITS; k++) begin
            int j;
            j = (int'(ptr) + k) % N_UNITS;
            if (!any && req[j]) begin
                any      = 1'b1;
                grant[j] = 1'b1;
                next_ptr = IDX_W'((j + 1) % N_UNITS);
            end
        end
    end
endmodule

// File: rtl/ipi_dest_match.sv
module ipi_dest_match #(
    parameter int N_UNITS = 8,
    localparam int IDX_W  = $clog2(N_UNITS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_wr,
    input  logic [31:0]            cmd_lo,
    input  logic [31:0]            cmd_hi,
    input  logic [IDX_W-1:0]       sender_idx,
    input  logic [N_UNITS*32-1:0]  unit_id,
    input  logic [N_UNITS*32-1:0]  unit_ldr,
    input  logic [N_UNITS*32-1:0]  unit_dfr,
    output logic                   busy,
    output logic                   tgt_valid,
    output logic [N_UNITS-1:0]     tgt_mask,
    output logic [31:0]            lo_word,
    output logic [31:0]            hi_word,
    output logic [7:0]             vector,
    output logic [2:0]             dmode,
    output logic                   logical,
    output logic                   level,
    output logic                   trig
);
    import ipi_pkg::*;

    ipi_state_t state_q, state_d;

    logic [31:0]        lo_q, hi_q;
    logic [IDX_W-1:0]   sender_q;
    logic [IDX_W-1:0]   rr_ptr_q;
    logic [N_UNITS-1:0] set_q;
    logic [N_UNITS-1:0] hit_vec;
    logic [N_UNITS-1:0] grant;
    logic               grant_any;
    logic [IDX_W-1:0]   rr_next;
    logic               accept;

    assign accept = cmd_wr && (state_q == ST_IDLE);

    // per-unit match
    genvar gi;
    generate
        for (gi = 0; gi < N_UNITS; gi++) begin : g_unit
            unit_match #(.IDX_W(IDX_W), .UNIT_IDX(gi)) u_match (
                .shorthand (lo_q[19:18]),
                .logical   (lo_q[11]),
                .dest      (hi_q[31:24]),
                .sender    (sender_q),
                .id_reg    (unit_id[gi*32 +: 32]),
                .ldr_reg   (unit_ldr[gi*32 +: 32]),
                .dfr_reg   (unit_dfr[gi*32 +: 32]),
                .hit       (hit_vec[gi])
            );
        end
    endgenerate

    rr_picker #(.N_UNITS(N_UNITS)) u_rr (
        .req      (set_q),
        .ptr      (rr_ptr_q),
        .grant    (grant),
        .any      (grant_any),
        .next_ptr (rr_next)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_wr) state_d = ST_EVAL;
            ST_EVAL: state_d = (lo_q[10:8] == DM_LOWEST) ? ST_PICK : ST_EMIT;
            ST_PICK: state_d = ST_EMIT;
            ST_EMIT: state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q     <= '0;
            hi_q     <= '0;
            sender_q <= '0;
            set_q    <= '0;
            rr_ptr_q <= '0;
        end else begin
            if (accept) begin
                lo_q             <= cmd_lo;
                lo_q[STATUS_BIT] <= 1'b0;
                hi_q             <= {cmd_hi[31:24], 24'h0};
                sender_q         <= sender_idx;
            end
            if (state_q == ST_EVAL)
                set_q <= (lo_q[10:8] == DM_RSVD) ? '0 : hit_vec;
            if (state_q == ST_PICK) begin
                set_q <= grant;
                if (grant_any) rr_ptr_q <= rr_next;
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        tgt_valid = (state_q == ST_EMIT);
        tgt_mask  = tgt_valid ? set_q : '0;
        lo_word   = lo_q;
        hi_word   = hi_q;
        vector    = lo_q[7:0];
        dmode     = lo_q[10:8];
        logical   = lo_q[11];
        level     = lo_q[14];
        trig      = lo_q[15];
    end
endmodule

// File: rtl/ipi_dest_match_chk.sv
module ipi_dest_match_chk #(
    parameter int N_UNITS = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_wr,
    input logic               busy,
    input logic               tgt_valid,
    input logic [N_UNITS-1:0] tgt_mask,
    input logic [2:0]         dmode,
    input logic [31:0]        lo_word
);
    // R2: accepted write makes the block busy
    p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy) |=> busy);

    // R2: target pulse lasts one cycle
    p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |=> !tgt_valid);

    // R2: back to idle after the pulse
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |=> !busy);

    // R2: stored command is stable while a send is in flight
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(lo_word));

    // R3: self shorthand reaches at most one unit
    p_self_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_valid && lo_word[19:18] == 2'd1) |-> ($countones(tgt_mask) <= 1));

    // R8: lowest priority targets at most one unit
    p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_valid && dmode == 3'd1) |-> $onehot0(tgt_mask));

    // R10: reserved mode delivers nowhere
    p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_valid && dmode == 3'd3) |-> (tgt_mask == '0));
endmodule

bind ipi_dest_match ipi_dest_match_chk #(.N_UNITS(N_UNITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .busy      (busy),
    .tgt_valid (tgt_valid),
    .tgt_mask  (tgt_mask),
    .dmode     (dmode),
    .lo_word   (lo_word)
);

// File: tb/tb_ipi_dest_match.sv
module tb_ipi_dest_match;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_wr = 1'b0;
    logic [31:0] cmd_lo = '0, cmd_hi = '0;
    logic [2:0]  sender_idx = '0;
    logic [31:0] ids [N];
    logic [31:0] ldrs[N];
    logic [31:0] dfrs[N];
    logic [N*32-1:0] unit_id, unit_ldr, unit_dfr;
    logic busy, tgt_valid, logical, level, trig;
    logic [N-1:0] tgt_mask;
    logic [31:0] lo_word, hi_word;
    logic [7:0] vector;
    logic [2:0] dmode;

    int total = 0;
    int bad = 0;
    int model_ptr = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            unit_id[i*32 +: 32]  = ids[i];
            unit_ldr[i*32 +: 32] = ldrs[i];
            unit_dfr[i*32 +: 32] = dfrs[i];
        end
    end

    ipi_dest_match #(.N_UNITS(N)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_lo(cmd_lo), .cmd_hi(cmd_hi),
        .sender_idx(sender_idx), .unit_id(unit_id), .unit_ldr(unit_ldr), .unit_dfr(unit_dfr),
        .busy(busy), .tgt_valid(tgt_valid), .tgt_mask(tgt_mask), .lo_word(lo_word),
        .hi_word(hi_word), .vector(vector), .dmode(dmode), .logical(logical),
        .level(level), .trig(trig)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int vec, input int dm, input int lg, input int sh);
        return 32'(vec) | (32'(dm) << 8) | (32'(lg) << 11) | (32'(sh) << 18);
    endfunction

    // behavioural reference: which units does the command reach
    function automatic logic [N-1:0] ref_match(input logic [31:0] lo, input logic [31:0] hi, input int snd);
        logic [N-1:0] m;
        int sh, d;
        sh = int'(lo[19:18]);
        d  = int'(hi[31:24]);
        m  = '0;
        for (int i = 0; i < N; i++) begin
            int lid;
            lid = int'(ldrs[i][31:24]);
            if (sh == 1) m[i] = (i == snd);
            else if (sh == 2) m[i] = 1'b1;
            else if (sh == 3) m[i] = (i != snd);
            else if (lo[11] == 1'b0) m[i] = (int'(ids[i][31:24]) == d);
            else if (dfrs[i] == 32'hFFFF_FFFF) m[i] = ((lid & d) != 0);
            else m[i] = ((lid % 16) == (d % 16)) && (((lid / 16) & (d / 16)) != 0);
        end
        if (lo[10:8] == 3'd3) m = '0;
        return m;
    endfunction

    task automatic send(input logic [31:0] lo, input logic [31:0] hi, input int snd,
                        input string req, input bit poke);
        logic [N-1:0] exp;
        int lat;
        bit lowest;
        exp = ref_match(lo, hi, snd);
        lowest = (lo[10:8] == 3'd1);
        if (lowest) begin
            logic [N-1:0] pick;
            pick = '0;
            for (int k = 0; k < N; k++) begin
                int j;
                j = (model_ptr + k) % N;
                if (pick == '0 && exp[j]) begin
                    pick[j] = 1'b1;
                    model_ptr = (j + 1) % N;
                end
            end
            exp = pick;
        end
        lat = lowest ? 3 : 2;
        @(negedge clk);
        cmd_lo = lo; cmd_hi = hi; sender_idx = 3'(snd); cmd_wr = 1'b1;
        @(negedge clk);
        if (poke) begin
            cmd_lo = mk(8'h77, 0, 0, 2); cmd_hi = 32'hFF00_0000;
        end else cmd_wr = 1'b0;
        check({req, " busy R2"}, 32'(busy), 32'd1);
        check("lo_word R1", lo_word, lo & ~32'h0000_1000);
        check("hi_word R1", hi_word, {hi[31:24], 24'h0});
        check("vector R1", 32'(vector), 32'(lo[7:0]));
        check("dmode R1", 32'(dmode), 32'(lo[10:8]));
        check("logical R1", 32'(logical), 32'(lo[11]));
        check("level R1", 32'(level), 32'(lo[14]));
        check("trig R1", 32'(trig), 32'(lo[15]));
        check({req, " valid R2"}, 32'(tgt_valid), 32'd0);
        for (int k = 2; k <= lat + 1; k++) begin
            @(negedge clk);
            cmd_wr = 1'b0;
            check({req, " valid R2"}, 32'(tgt_valid), 32'(k == lat));
            check({req, " mask"}, 32'(tgt_mask), (k == lat) ? 32'(exp) : 32'd0);
        end
        check({req, " idle R2"}, 32'(busy), 32'd0);
        if (poke) check("ignored write R2", lo_word, lo & ~32'h0000_1000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            ids[i]  = (32'h20 + 32'(i)) << 24;
            ldrs[i] = (32'd1 << i) << 24;
            dfrs[i] = 32'hFFFF_FFFF;
        end
        repeat (3) @(negedge clk);
        // R11 reset state
        check("reset busy R11", 32'(busy), 32'd0);
        check("reset valid R11", 32'(tgt_valid), 32'd0);
        check("reset mask R11", 32'(tgt_mask), 32'd0);
        check("reset lo R11", lo_word, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R5 physical, status bit forced clear
        send(mk(8'h45, 0, 0, 0) | 32'h0000_D000 | 32'hF003_0000, 32'h23AB_CDEF, 0, "phys R5", 0);
        send(mk(8'h46, 0, 0, 0), 32'h9900_0000, 1, "phys none R5", 0);
        // R3 / R4 shorthands
        send(mk(8'h50, 0, 1, 1), 32'h0, 5, "self R3", 0);
        send(mk(8'h51, 4, 0, 2), 32'h0, 2, "all R4", 0);
        send(mk(8'h52, 0, 0, 3), 32'h0, 2, "others R4", 0);
        // R6 flat logical
        send(mk(8'h60, 0, 1, 0), 32'h8100_0000, 0, "flat R6", 0);
        send(mk(8'h61, 0, 1, 0), 32'h0000_0000, 0, "flat zero R6", 0);
        // R10 reserved mode
        send(mk(8'h62, 3, 0, 2), 32'h0, 0, "reserved R10", 0);
        // R8 round robin
        send(mk(8'h70, 1, 0, 2), 32'h0, 0, "lowest all R8", 0);
        send(mk(8'h70, 1, 0, 2), 32'h0, 0, "lowest all R8", 0);
        send(mk(8'h70, 1, 0, 2), 32'h0, 0, "lowest all R8", 0);
        send(mk(8'h71, 1, 0, 0), 32'h2500_0000, 0, "lowest phys R8", 0);
        send(mk(8'h72, 1, 1, 0), 32'h4400_0000, 0, "lowest flat R8", 0);
        send(mk(8'h72, 1, 1, 0), 32'h4400_0000, 0, "lowest wrap R8", 0);
        // R9 empty lowest leaves pointer alone
        send(mk(8'h73, 1, 0, 0), 32'h9900_0000, 0, "lowest empty R9", 0);
        send(mk(8'h74, 1, 0, 2), 32'h0, 0, "pointer kept R9", 0);
        // R2 write while busy ignored
        send(mk(8'h80, 0, 0, 0), 32'h2200_0000, 0, "busy write R2", 1);
        // R7 cluster logical
        for (int i = 0; i < N; i++) begin
            dfrs[i] = 32'h0FFF_FFFF;
            ldrs[i] = {4'(1 << (i % 4)), 4'(i / 4), 24'h0};
        end
        send(mk(8'h90, 0, 1, 0), 32'h3100_0000, 0, "cluster R7", 0);
        send(mk(8'h91, 0, 1, 0), 32'h1100_0000, 0, "cluster one R7", 0);
        send(mk(8'h92, 0, 1, 0), 32'h0200_0000, 0, "cluster no member R7", 0);
        // mixed formats: unit 0 flat, others cluster
        dfrs[0] = 32'hFFFF_FFFF;
        ldrs[0] = 32'h0100_0000;
        send(mk(8'h93, 0, 1, 0), 32'h1100_0000, 0, "mixed R6", 0);
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule